// File: doc/BRIEF.md
# Interrupt Redirection Register File

This block holds the programmable state of a 24-input interrupt redirection controller. Software reaches it indirectly, through two 32-bit locations on a small register bus. It first writes a register index into the select location. It then reads or writes the data window, which acts on whatever that index names. Behind the window sit:

- a controller identifier, with a mirror of it at a second index;
- a fixed, read-only version word;
- one configuration word and one destination word per interrupt input.

Every stored routing field of every entry is driven out in parallel to the routing logic. That logic owns two status bits in each configuration word: a remote-acknowledge flag (bit 14) and a delivery-pending flag (bit 12). It sets and clears them through per-entry strobes, and bus writes never change them. Each write to a configuration word raises a one-cycle re-evaluate strobe that carries the entry number, so the router can examine that input again.

Bus writes take effect on the rising clock edge. Read data is combinational from the current address and stored state.

Top module: `irq_redir_regfile`

## Requirements
- R1: Byte offset 0x00 is the select location and byte offset 0x10 is the data window. A read at any other offset returns zero, and a write there changes no state.
- R2: A read at offset 0x00 returns the full 32-bit value last written there. After reset it returns zero.
- R3: Index 0 stores a 4-bit identifier, taken from bits 27:24 of the written word. Reads return it in bits 27:24 with all other bits zero. Index 2 reads the same value.
- R4: Index 1 reads as 0x11 in bits 7:0 and the highest entry number (NUM_ENT-1, i.e. 23) in bits 23:16, with all other bits zero. Writes to index 1 and index 2 are discarded.
- R5: Entry n is addressed as follows, and any other index reads zero and ignores writes:
  - its configuration word is at index 0x10+2n;
  - its destination word is at index 0x11+2n.
- R6: A destination word keeps only bits 31:24. Its lower bits read as zero.
- R7: A configuration word write replaces only bits 16:15, 13 and 11:0. Bits 14 and 12 keep their previous values, and bits 31:17 always read zero. The fields are:
  - bits 7:0 vector;
  - bits 10:8 delivery mode;
  - bit 11 destination mode;
  - bit 13 polarity;
  - bit 15 trigger mode (1 = level);
  - bit 16 mask.
- R8: Reset leaves the following state:
  - every configuration word reads 0x00010000 (only the mask set);
  - every destination word reads zero;
  - the identifier and the select value are zero;
  - no re-evaluate strobe is raised.
- R9: The stored fields of entry n are driven on the flat outputs as follows:
  - `ent_vector[8n+:8]`, `ent_dmode[3n+:3]` and `ent_dest[8n+:8]` carry the vector, delivery mode and destination byte;
  - bit n of `ent_dstmode`, `ent_level`, `ent_mask`, `ent_rirr` and `ent_dlvs` carries the single-bit fields.
- R10: A write to the configuration word of entry n raises `reeval_vld` with `reeval_idx` = n for the one cycle that follows the write edge. Destination writes, other writes and idle cycles raise no strobe.
- R11: The status strobes act at the clock edge:
  - a set strobe for an entry forces its status bit to 1;
  - a clear strobe forces it to 0;
  - set wins when both are high in the same cycle;
  - the status bits change only through these strobes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, sampled at the rising edge |
| bus_addr | input | ADDR_W (8) | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| stat_rirr_set | input | NUM_ENT | Per-entry set strobe for the remote-acknowledge bit |
| stat_rirr_clr | input | NUM_ENT | Per-entry clear strobe for the remote-acknowledge bit |
| stat_dlvs_set | input | NUM_ENT | Per-entry set strobe for the delivery-pending bit |
| stat_dlvs_clr | input | NUM_ENT | Per-entry clear strobe for the delivery-pending bit |
| ent_vector | output | 8*NUM_ENT | Vector of each entry |
| ent_dmode | output | 3*NUM_ENT | Delivery mode of each entry |
| ent_dstmode | output | NUM_ENT | Destination mode of each entry |
| ent_level | output | NUM_ENT | Level trigger flag of each entry |
| ent_mask | output | NUM_ENT | Mask of each entry |
| ent_rirr | output | NUM_ENT | Remote-acknowledge status of each entry |
| ent_dlvs | output | NUM_ENT | Delivery-pending status of each entry |
| ent_dest | output | 8*NUM_ENT | Destination byte of each entry |
| reeval_vld | output | 1 | One-cycle strobe after a configuration write |
| reeval_idx | output | IDX_W (5) | Entry number that goes with `reeval_vld` |

## Verification
The bench builds the block with its default parameters: 24 entries and an 8-bit byte offset. With these values the version word carries 23, and the last table index is 0x3F. This brings within reach both the final entry (configuration at 0x3E, destination at 0x3F) and the first index past the table (0x40), so the upper edge of the table decode is exercised from both sides. With 24 entries the entry number also needs a 5-bit index that is not fully used. This shows that an index select left over from a non-power-of-two table neither aliases into nor corrupts real entries.

// File: rtl/irr_pkg.sv
package irr_pkg;

    localparam int unsigned WORD_W   = 32;
    localparam int unsigned OFF_SEL  = 32'h00;
    localparam int unsigned OFF_WIN  = 32'h10;
    localparam int unsigned IDX_ID   = 0;
    localparam int unsigned IDX_VER  = 1;
    localparam int unsigned IDX_ARB  = 2;
    localparam int unsigned IDX_TBL  = 32'h10;
    localparam logic [7:0]  VER_CODE = 8'h11;

    typedef enum logic [2:0] {
        WK_NONE,
        WK_ID,
        WK_VER,
        WK_ARB,
        WK_CFG,
        WK_DST
    } win_kind_e;

    // Bit order matches the configuration word, bits 16 down to 0.
    typedef struct packed {
        logic       mask;
        logic       level;
        logic       rirr;
        logic       pol;
        logic       dlvs;
        logic       dstmode;
        logic [2:0] dmode;
        logic [7:0] vector;
    } cfg_t;

    localparam cfg_t CFG_RESET = cfg_t'(17'h1_0000);

    // New word from the bus, with the status bits kept from the old word.
    function automatic cfg_t cfg_merge(cfg_t old, logic [WORD_W-1:0] wd);
        cfg_t n;
        n      = cfg_t'(wd[16:0]);
        n.rirr = old.rirr;
        n.dlvs = old.dlvs;
        return n;
    endfunction

    function automatic logic [WORD_W-1:0] cfg_word(cfg_t c);
        return {15'd0, c};
    endfunction

    function automatic logic [WORD_W-1:0] ver_word(int unsigned n_ent);
        logic [7:0] top;
        top = 8'(n_ent - 1);
        return {8'd0, top, 8'd0, VER_CODE};
    endfunction

endpackage

// File: rtl/irr_window_dec.sv
module irr_window_dec
    import irr_pkg::*;
#(
    parameter int NUM_ENT = 24,
    parameter int ADDR_W  = 8,
    parameter int IDX_W   = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] sel_q,
    output logic              sel_hit,
    output logic              win_hit,
    output win_kind_e         kind,
    output logic [IDX_W-1:0]  ent_idx
);

    localparam logic [WORD_W-1:0] TBL_LO = WORD_W'(IDX_TBL);
    localparam logic [WORD_W-1:0] TBL_HI = WORD_W'(IDX_TBL + 2 * NUM_ENT);

    logic [WORD_W-1:0] tbl_off;

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q <= '0;
        end else if (bus_wr && sel_hit) begin
            sel_q <= bus_wdata;
        end
    end

    always_comb begin
        sel_hit = (bus_addr == ADDR_W'(OFF_SEL));
        win_hit = (bus_addr == ADDR_W'(OFF_WIN));
        tbl_off = sel_q - TBL_LO;
        ent_idx = tbl_off[IDX_W:1];
        kind    = WK_NONE;
        if (sel_q == WORD_W'(IDX_ID)) begin
            kind = WK_ID;
        end else if (sel_q == WORD_W'(IDX_VER)) begin
            kind = WK_VER;
        end else if (sel_q == WORD_W'(IDX_ARB)) begin
            kind = WK_ARB;
        end else if (sel_q >= TBL_LO && sel_q < TBL_HI) begin
            kind = tbl_off[0] ? WK_DST : WK_CFG;
        end
    end

endmodule

// File: rtl/irr_entry.sv
module irr_entry
    import irr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic              dst_we,
    input  logic [WORD_W-1:0] wdata,
    input  logic              rirr_set,
    input  logic              rirr_clr,
    input  logic              dlvs_set,
    input  logic              dlvs_clr,
    output cfg_t              cfg_q,
    output logic [7:0]        dest_q
);

    cfg_t cfg_nxt;

    always_comb begin
        cfg_nxt = cfg_we ? cfg_merge(cfg_q, wdata) : cfg_q;
        if (rirr_clr) cfg_nxt.rirr = 1'b0;
        if (rirr_set) cfg_nxt.rirr = 1'b1;
        if (dlvs_clr) cfg_nxt.dlvs = 1'b0;
        if (dlvs_set) cfg_nxt.dlvs = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q  <= CFG_RESET;
            dest_q <= '0;
        end else begin
            cfg_q <= cfg_nxt;
            if (dst_we) begin
                dest_q <= wdata[31:24];
            end
        end
    end

endmodule

// File: rtl/irr_read_mux.sv
module irr_read_mux
    import irr_pkg::*;
#(
    parameter int NUM_ENT = 24,
    parameter int IDX_W   = 5
) (
    input  logic                      sel_hit,
    input  logic                      win_hit,
    input  logic [WORD_W-1:0]         sel_q,
    input  win_kind_e                 kind,
    input  logic [IDX_W-1:0]          ent_idx,
    input  logic [3:0]                id_q,
    input  cfg_t [NUM_ENT-1:0]        cfg_arr,
    input  logic [NUM_ENT-1:0][7:0]   dest_arr,
    output logic [WORD_W-1:0]         rdata
);

    logic [WORD_W-1:0] win_data;

    always_comb begin
        unique case (kind)
            WK_ID, WK_ARB: win_data = {4'd0, id_q, 24'd0};
            WK_VER:        win_data = ver_word(NUM_ENT);
            WK_CFG:        win_data = cfg_word(cfg_arr[ent_idx]);
            WK_DST:        win_data = {dest_arr[ent_idx], 24'd0};
            default:       win_data = '0;
        endcase
        if (sel_hit) begin
            rdata = sel_q;
        end else if (win_hit) begin
            rdata = win_data;
        end else begin
            rdata = '0;
        end
    end

endmodule

// File: rtl/irq_redir_regfile.sv
module irq_redir_regfile
    import irr_pkg::*;
#(
    parameter int NUM_ENT = 24,
    parameter int ADDR_W  = 8,
    localparam int IDX_W  = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   bus_wr,
    input  logic [ADDR_W-1:0]      bus_addr,
    input  logic [31:0]            bus_wdata,
    output logic [31:0]            bus_rdata,
    input  logic [NUM_ENT-1:0]     stat_rirr_set,
    input  logic [NUM_ENT-1:0]     stat_rirr_clr,
    input  logic [NUM_ENT-1:0]     stat_dlvs_set,
    input  logic [NUM_ENT-1:0]     stat_dlvs_clr,
    output logic [8*NUM_ENT-1:0]   ent_vector,
    output logic [3*NUM_ENT-1:0]   ent_dmode,
    output logic [NUM_ENT-1:0]     ent_dstmode,
    output logic [NUM_ENT-1:0]     ent_level,
    output logic [NUM_ENT-1:0]     ent_mask,
    output logic [NUM_ENT-1:0]     ent_rirr,
    output logic [NUM_ENT-1:0]     ent_dlvs,
    output logic [8*NUM_ENT-1:0]   ent_dest,
    output logic                   reeval_vld,
    output logic [IDX_W-1:0]       reeval_idx
);

    logic [WORD_W-1:0]       sel_q;
    logic                    sel_hit;
    logic                    win_hit;
    win_kind_e               kind;
    logic [IDX_W-1:0]        ent_idx;
    logic [3:0]              id_q;
    logic                    win_wr;
    cfg_t [NUM_ENT-1:0]      cfg_arr;
    logic [NUM_ENT-1:0][7:0] dest_arr;

    irr_window_dec #(
        .NUM_ENT (NUM_ENT),
        .ADDR_W  (ADDR_W),
        .IDX_W   (IDX_W)
    ) u_dec (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .sel_q     (sel_q),
        .sel_hit   (sel_hit),
        .win_hit   (win_hit),
        .kind      (kind),
        .ent_idx   (ent_idx)
    );

    assign win_wr = bus_wr && win_hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            id_q       <= '0;
            reeval_vld <= 1'b0;
            reeval_idx <= '0;
        end else begin
            if (win_wr && kind == WK_ID) begin
                id_q <= bus_wdata[27:24];
            end
            reeval_vld <= win_wr && (kind == WK_CFG);
            if (win_wr && kind == WK_CFG) begin
                reeval_idx <= ent_idx;
            end
        end
    end

    for (genvar i = 0; i < NUM_ENT; i++) begin : g_ent
        logic cfg_we_i;
        logic dst_we_i;

        assign cfg_we_i = win_wr && (kind == WK_CFG) && (ent_idx == IDX_W'(i));
        assign dst_we_i = win_wr && (kind == WK_DST) && (ent_idx == IDX_W'(i));

        irr_entry u_ent (
            .clk      (clk),
            .rst      (rst),
            .cfg_we   (cfg_we_i),
            .dst_we   (dst_we_i),
            .wdata    (bus_wdata),
            .rirr_set (stat_rirr_set[i]),
            .rirr_clr (stat_rirr_clr[i]),
            .dlvs_set (stat_dlvs_set[i]),
            .dlvs_clr (stat_dlvs_clr[i]),
            .cfg_q    (cfg_arr[i]),
            .dest_q   (dest_arr[i])
        );

        assign ent_vector[8*i +: 8] = cfg_arr[i].vector;
        assign ent_dmode[3*i +: 3]  = cfg_arr[i].dmode;
        assign ent_dstmode[i]       = cfg_arr[i].dstmode;
        assign ent_level[i]         = cfg_arr[i].level;
        assign ent_mask[i]          = cfg_arr[i].mask;
        assign ent_rirr[i]          = cfg_arr[i].rirr;
        assign ent_dlvs[i]          = cfg_arr[i].dlvs;
        assign ent_dest[8*i +: 8]   = dest_arr[i];
    end

    irr_read_mux #(
        .NUM_ENT (NUM_ENT),
        .IDX_W   (IDX_W)
    ) u_rmux (
        .sel_hit  (sel_hit),
        .win_hit  (win_hit),
        .sel_q    (sel_q),
        .kind     (kind),
        .ent_idx  (ent_idx),
        .id_q     (id_q),
        .cfg_arr  (cfg_arr),
        .dest_arr (dest_arr),
        .rdata    (bus_rdata)
    );

endmodule

// File: rtl/irr_regfile_chk.sv
module irr_regfile_chk #(
    parameter int NUM_ENT = 24,
    parameter int ADDR_W  = 8,
    parameter int IDX_W   = 5
) (
    input logic               clk,
    input logic               rst,
    input logic               bus_wr,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic [31:0]        bus_rdata,
    input logic [NUM_ENT-1:0] stat_rirr_set,
    input logic [NUM_ENT-1:0] stat_rirr_clr,
    input logic [NUM_ENT-1:0] stat_dlvs_set,
    input logic [NUM_ENT-1:0] stat_dlvs_clr,
    input logic [NUM_ENT-1:0] ent_rirr,
    input logic [NUM_ENT-1:0] ent_dlvs,
    input logic               reeval_vld,
    input logic [IDX_W-1:0]   reeval_idx
);

    AST_STRAY_OFFSET_ZERO: assert property (@(posedge clk) disable iff (rst)
        (bus_addr != ADDR_W'(0) && bus_addr != ADDR_W'(16)) |-> bus_rdata == 32'd0); // R1

    AST_REEVAL_FROM_WRITE: assert property (@(posedge clk) disable iff (rst)
        reeval_vld |-> ($past(bus_wr) && $past(bus_addr) == ADDR_W'(16))); // R10

    AST_REEVAL_IDX_RANGE: assert property (@(posedge clk) disable iff (rst)
        reeval_vld |-> (32'(reeval_idx) < NUM_ENT)); // R10

    AST_IDLE_NO_REEVAL: assert property (@(posedge clk) disable iff (rst)
        !bus_wr |=> !reeval_vld); // R10

    AST_RIRR_SET_TAKES: assert property (@(posedge clk) disable iff (rst)
        (|stat_rirr_set) |=> ((ent_rirr & $past(stat_rirr_set)) == $past(stat_rirr_set))); // R11

    AST_RIRR_CLR_TAKES: assert property (@(posedge clk) disable iff (rst)
        (|(stat_rirr_clr & ~stat_rirr_set)) |=>
            ((ent_rirr & $past(stat_rirr_clr & ~stat_rirr_set)) == '0)); // R11

    AST_STATUS_HELD: assert property (@(posedge clk) disable iff (rst)
        (stat_rirr_set == '0 && stat_rirr_clr == '0 && stat_dlvs_set == '0 && stat_dlvs_clr == '0)
            |=> ($stable(ent_rirr) && $stable(ent_dlvs))); // R7

endmodule

bind irq_redir_regfile irr_regfile_chk #(
    .NUM_ENT (NUM_ENT),
    .ADDR_W  (ADDR_W),
    .IDX_W   (IDX_W)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .bus_wr        (bus_wr),
    .bus_addr      (bus_addr),
    .bus_rdata     (bus_rdata),
    .stat_rirr_set (stat_rirr_set),
    .stat_rirr_clr (stat_rirr_clr),
    .stat_dlvs_set (stat_dlvs_set),
    .stat_dlvs_clr (stat_dlvs_clr),
    .ent_rirr      (ent_rirr),
    .ent_dlvs      (ent_dlvs),
    .reeval_vld    (reeval_vld),
    .reeval_idx    (reeval_idx)
);

// File: tb/irq_redir_regfile_test.sv
`timescale 1ns/1ps
module irq_redir_regfile_test;

    localparam int NUM_ENT = 24;
    localparam int ADDR_W  = 8;
    localparam int IDX_W   = 5;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 bus_wr = 1'b0;
    logic [ADDR_W-1:0]    bus_addr = '0;
    logic [31:0]          bus_wdata = '0;
    logic [31:0]          bus_rdata;
    logic [NUM_ENT-1:0]   stat_rirr_set = '0;
    logic [NUM_ENT-1:0]   stat_rirr_clr = '0;
    logic [NUM_ENT-1:0]   stat_dlvs_set = '0;
    logic [NUM_ENT-1:0]   stat_dlvs_clr = '0;
    logic [8*NUM_ENT-1:0] ent_vector;
    logic [3*NUM_ENT-1:0] ent_dmode;
    logic [NUM_ENT-1:0]   ent_dstmode;
    logic [NUM_ENT-1:0]   ent_level;
    logic [NUM_ENT-1:0]   ent_mask;
    logic [NUM_ENT-1:0]   ent_rirr;
    logic [NUM_ENT-1:0]   ent_dlvs;
    logic [8*NUM_ENT-1:0] ent_dest;
    logic                 reeval_vld;
    logic [IDX_W-1:0]     reeval_idx;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    irq_redir_regfile #(.NUM_ENT(NUM_ENT), .ADDR_W(ADDR_W)) uut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .stat_rirr_set(stat_rirr_set), .stat_rirr_clr(stat_rirr_clr),
        .stat_dlvs_set(stat_dlvs_set), .stat_dlvs_clr(stat_dlvs_clr),
        .ent_vector(ent_vector), .ent_dmode(ent_dmode), .ent_dstmode(ent_dstmode),
        .ent_level(ent_level), .ent_mask(ent_mask), .ent_rirr(ent_rirr),
        .ent_dlvs(ent_dlvs), .ent_dest(ent_dest),
        .reeval_vld(reeval_vld), .reeval_idx(reeval_idx)
    );

    typedef struct packed {
        logic [31:0] idx;
        logic [31:0] wd;
        logic [31:0] exp;
    } vec_t;

    // Select an index, write the window, read the window back.
    localparam vec_t VECS [10] = '{
        '{32'h00, 32'hFFFF_FFFF, 32'h0F00_0000},  // R3 only id bits kept
        '{32'h02, 32'h1234_5678, 32'h0F00_0000},  // R3 R4 mirror, write dropped
        '{32'h01, 32'h0000_0000, 32'h0017_0011},  // R4 version word
        '{32'h10, 32'hFFFF_FFFF, 32'h0001_AFFF},  // R7 writable bits only
        '{32'h11, 32'hFFFF_FFFF, 32'hFF00_0000},  // R6 top byte only
        '{32'h3E, 32'h0000_8923, 32'h0000_8923},  // R5 last config word
        '{32'h3F, 32'hA512_3456, 32'hA500_0000},  // R5 R6 last destination word
        '{32'h40, 32'hFFFF_FFFF, 32'h0000_0000},  // R5 just past table
        '{32'h03, 32'hFFFF_FFFF, 32'h0000_0000},  // R5 gap index
        '{32'h0F, 32'hFFFF_FFFF, 32'h0000_0000}   // R5 gap below table
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [31:0] d;
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R8 reset state
        rd(8'h00, d);
        check("R8 select", d, 32'h0);
        rd(8'h10, d);
        check("R8 id", d, 32'h0);
        check("R8 mask out", 32'(ent_mask), 32'h00FF_FFFF);
        check("R8 dest out", 32'(|ent_dest), 32'h0);
        check("R8 reeval", 32'(reeval_vld), 32'h0);
        wr(8'h00, 32'h26);
        rd(8'h10, d);
        check("R8 cfg reset", d, 32'h0001_0000);
        wr(8'h00, 32'h27);
        rd(8'h10, d);
        check("R8 dest reset", d, 32'h0);

        // table walk
        foreach (VECS[i]) begin
            wr(8'h00, VECS[i].idx);
            wr(8'h10, VECS[i].wd);
            rd(8'h10, d);
            check($sformatf("R5 vec %0d idx %02h", i, VECS[i].idx), d, VECS[i].exp);
        end

        // R9 exposed fields of entry 23
        check("R9 vector", 32'(ent_vector[8*23 +: 8]), 32'h23);
        check("R9 dmode", 32'(ent_dmode[3*23 +: 3]), 32'h1);
        check("R9 dstmode", 32'(ent_dstmode[23]), 32'h1);
        check("R9 level", 32'(ent_level[23]), 32'h1);
        check("R9 mask", 32'(ent_mask[23]), 32'h0);
        check("R9 dest", 32'(ent_dest[8*23 +: 8]), 32'hA5);

        // R10 re-evaluate strobe
        wr(8'h00, 32'h1A);
        wr(8'h10, 32'h55);
        check("R10 strobe high", 32'(reeval_vld), 32'h1);
        check("R10 strobe index", 32'(reeval_idx), 32'h5);
        @(negedge clk);
        check("R10 strobe one cycle", 32'(reeval_vld), 32'h0);
        wr(8'h00, 32'h1B);
        wr(8'h10, 32'hFF00_0000);
        check("R10 no strobe on dest", 32'(reeval_vld), 32'h0);

        // R11 and R7 status bits against writes (entry 0 holds 0x1AFFF)
        @(negedge clk);
        stat_rirr_set[0] = 1'b1;
        stat_dlvs_set[0] = 1'b1;
        @(negedge clk);
        stat_rirr_set = '0;
        stat_dlvs_set = '0;
        wr(8'h00, 32'h10);
        rd(8'h10, d);
        check("R11 status set", d, 32'h0001_FFFF);
        wr(8'h10, 32'h0);
        rd(8'h10, d);
        check("R7 status kept on write", d, 32'h0000_5000);
        @(negedge clk);
        stat_rirr_set[0] = 1'b1;
        stat_rirr_clr[0] = 1'b1;
        @(negedge clk);
        stat_rirr_set = '0;
        stat_rirr_clr = '0;
        #1;
        check("R11 set wins", 32'(ent_rirr[0]), 32'h1);
        @(negedge clk);
        stat_rirr_clr[0] = 1'b1;
        stat_dlvs_clr[0] = 1'b1;
        @(negedge clk);
        stat_rirr_clr = '0;
        stat_dlvs_clr = '0;
        rd(8'h10, d);
        check("R11 status clear", d, 32'h0);

        // R1 stray offsets, R2 select readback
        wr(8'h00, 32'hDEAD_BEEF);
        rd(8'h00, d);
        check("R2 select readback", d, 32'hDEAD_BEEF);
        wr(8'h08, 32'h0000_0033);
        rd(8'h00, d);
        check("R1 stray write ignored", d, 32'hDEAD_BEEF);
        rd(8'h04, d);
        check("R1 stray read zero", d, 32'h0);

        finish_run();
    end

endmodule